// File: doc/BRIEF.md
# Direct-Mapped Cache Lookup Array

This block keeps the tag, state and data-line storage of a direct-mapped cache and answers one word lookup at a time. A lookup carries a byte address, a load or store flag and a store word. When a lookup is accepted, the block reads the entry that the address selects into registers. On the following cycle it presents a response. The response sorts the access into one of three outcomes: load hit, store hit or miss.

On a load hit, the response returns the addressed word. On a store hit, the new word is merged into the line and the entry becomes Dirty; the storage is written when the response is taken. On a miss, the response returns the resident line with its tag and state, so a miss controller can decide whether the victim must be written back. A separate refill port writes a whole line, tag and state at an index. The miss controller uses it to install fetched lines. Sequencing of misses and the external memory belong to the controller, not to this block.

Top module: `cau_array_unit`

## Requirements
- R1: After reset every entry is Invalid, `req_ready` is 1 and `resp_valid` is 0.
- R2: The byte address splits as follows: bits [1:0] are the byte in a word and are ignored; bits [5:2] select one of 16 words in a line; the next IDX_W bits select the entry; all remaining upper bits are the tag.
- R3: A lookup hits only when the entry's state is not Invalid and its tag equals the address tag. `resp_kind` is 0 for a miss, 1 for a load hit and 2 for a store hit. On a hit, `resp_tag` equals the address tag.
- R4: On a load hit, `resp_word` is the addressed word of the stored line, and the entry is left unchanged.
- R5: On a store hit, the response line has the addressed word replaced by the store data, `resp_word` is that data, and `resp_status` is Dirty. When the response is taken, the entry holds that word and is Dirty.
- R6: On a miss, the response carries the stored line, tag and state exactly as held, and the entry is not modified.
- R7: State encoding: 0 is Invalid, 1 is Clean, 2 is Dirty. An Invalid entry never hits, even when its tag matches, and it reports state 0 on a miss.
- R8: A refill (`upd_valid`=1) writes line, tag and state together at `upd_index` on that clock edge.
- R9: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `resp_valid` rises on the next cycle and stays high until an edge with `resp_ready`=1. During that time `req_ready` is 0, and any request presented then has no effect.
- R10: A refill to the index of a lookup is visible in that lookup's response when the refill occurs on the same edge as the acceptance or while the response waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken on this edge |
| resp_kind | output | 2 | 0 miss, 1 load hit, 2 store hit |
| resp_word | output | 32 | Addressed word (after merge on store hit) |
| resp_line | output | 512 | Line, word k at bits [32k+31:32k] |
| resp_tag | output | TAG_W | Stored tag of the entry |
| resp_status | output | 2 | State of the entry (after merge) |
| upd_valid | input | 1 | Refill write enable |
| upd_index | input | IDX_W | Refill entry index |
| upd_line | input | 512 | Refill line data |
| upd_tag | input | TAG_W | Refill tag |
| upd_status | input | 2 | Refill state |

## Verification
The hardest case to reach from the ports is a refill that lands on the entry of a lookup that is already in flight. It can arrive while the response is held back, or on the very edge that accepts the request. The directed stimulus creates both cases. It stalls `resp_ready` for two cycles and drives a refill of the pending index in the first stalled cycle. It also drives a refill in the same cycle as a request. In both cases the entry starts with a different tag, so only a correctly forwarded refill can turn the response into a hit. A second stalled lookup presents a store to a resident line during the stall. A later load then shows that the word and its Clean state survived.

// File: rtl/cau_pkg.sv
package cau_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int LINE_WORDS = 16;
    localparam int WOFF_W     = $clog2(LINE_WORDS);
    localparam int BOFF_W     = $clog2(WORD_W / 8);
    localparam int LINE_OFF_W = WOFF_W + BOFF_W;
    localparam int LINE_W     = LINE_WORDS * WORD_W;

    typedef logic [LINE_WORDS-1:0][WORD_W-1:0] line_t;

    typedef enum logic [1:0] {
        ST_INVALID = 2'd0,
        ST_CLEAN   = 2'd1,
        ST_DIRTY   = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        K_MISS   = 2'd0,
        K_LD_HIT = 2'd1,
        K_ST_HIT = 2'd2
    } lookup_kind_e;

    function automatic logic [WOFF_W-1:0] word_sel(input logic [ADDR_W-1:0] a);
        return a[LINE_OFF_W-1:BOFF_W];
    endfunction

    function automatic logic [WORD_W-1:0] get_word(input line_t l, input logic [WOFF_W-1:0] o);
        return l[o];
    endfunction

    function automatic line_t put_word(input line_t l, input logic [WOFF_W-1:0] o,
                                       input logic [WORD_W-1:0] w);
        line_t r;
        r    = l;
        r[o] = w;
        return r;
    endfunction

endpackage

// File: rtl/cau_meta_store.sv
module cau_meta_store
    import cau_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_state_e      wr_st,
    input  logic             dirty_en,
    input  logic [IDX_W-1:0] dirty_idx,
    output logic [TAG_W-1:0] q_tag,
    output line_state_e      q_st
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        line_state_e      st;
    } meta_t;

    meta_t            mem [DEPTH];
    meta_t            q;
    meta_t            wr_m;
    logic [IDX_W-1:0] held;

    assign wr_m  = '{tag: wr_tag, st: wr_st};
    assign q_tag = q.tag;
    assign q_st  = q.st;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '{tag: '0, st: ST_INVALID};
            end
            held <= '0;
            q    <= '{tag: '0, st: ST_INVALID};
        end else begin
            if (dirty_en) mem[dirty_idx].st <= ST_DIRTY;
            if (wr_en)    mem[wr_idx] <= wr_m;
            if (rd_en) begin
                held <= rd_idx;
                q    <= (wr_en && wr_idx == rd_idx) ? wr_m : mem[rd_idx];
            end else if (wr_en && wr_idx == held) begin
                q <= wr_m;
            end
        end
    end

    logic             chk_wr, chk_d;
    logic [IDX_W-1:0] chk_wr_idx, chk_d_idx;
    meta_t            chk_wr_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_wr     <= 1'b0;
            chk_d      <= 1'b0;
            chk_wr_idx <= '0;
            chk_d_idx  <= '0;
            chk_wr_m   <= '{tag: '0, st: ST_INVALID};
        end else begin
            chk_wr     <= wr_en;
            chk_d      <= dirty_en;
            chk_wr_idx <= wr_idx;
            chk_d_idx  <= dirty_idx;
            chk_wr_m   <= wr_m;
        end
    end

    AST_REFILL_META: assert property (@(posedge clk) disable iff (rst)
        chk_wr |-> (mem[chk_wr_idx] == chk_wr_m)); // R8
    AST_STORE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (chk_d && !(chk_wr && chk_wr_idx == chk_d_idx)) |-> (mem[chk_d_idx].st == ST_DIRTY)); // R5

endmodule

// File: rtl/cau_line_store.sv
module cau_line_store
    import cau_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_t             wr_line,
    input  logic              ww_en,
    input  logic [IDX_W-1:0]  ww_idx,
    input  logic [WOFF_W-1:0] ww_off,
    input  logic [WORD_W-1:0] ww_data,
    output line_t             q
);
    localparam int DEPTH = 1 << IDX_W;

    line_t            mem [DEPTH];
    logic [IDX_W-1:0] held;

    always_ff @(posedge clk) begin
        if (ww_en) mem[ww_idx][ww_off] <= ww_data;
        if (wr_en) mem[wr_idx] <= wr_line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            q    <= '0;
        end else if (rd_en) begin
            held <= rd_idx;
            q    <= (wr_en && wr_idx == rd_idx) ? wr_line : mem[rd_idx];
        end else if (wr_en && wr_idx == held) begin
            q <= wr_line;
        end
    end

    logic              chk_ww, chk_wr;
    logic [IDX_W-1:0]  chk_ww_idx, chk_wr_idx;
    logic [WOFF_W-1:0] chk_ww_off;
    logic [WORD_W-1:0] chk_ww_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_ww      <= 1'b0;
            chk_wr      <= 1'b0;
            chk_ww_idx  <= '0;
            chk_wr_idx  <= '0;
            chk_ww_off  <= '0;
            chk_ww_data <= '0;
        end else begin
            chk_ww      <= ww_en;
            chk_wr      <= wr_en;
            chk_ww_idx  <= ww_idx;
            chk_wr_idx  <= wr_idx;
            chk_ww_off  <= ww_off;
            chk_ww_data <= ww_data;
        end
    end

    AST_STORE_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (chk_ww && !(chk_wr && chk_wr_idx == chk_ww_idx)) |-> (mem[chk_ww_idx][chk_ww_off] == chk_ww_data)); // R5

endmodule

// File: rtl/cau_lookup.sv
module cau_lookup
    import cau_pkg::*;
#(
    parameter int TAG_W = 22
) (
    input  logic              is_store,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [WOFF_W-1:0] req_off,
    input  logic [WORD_W-1:0] req_data,
    input  logic [TAG_W-1:0]  ent_tag,
    input  line_state_e       ent_st,
    input  line_t             ent_line,
    output lookup_kind_e      kind,
    output logic [WORD_W-1:0] word,
    output line_t             line,
    output line_state_e       st
);
    logic hit;

    always_comb begin
        hit  = (ent_st != ST_INVALID) && (ent_tag == req_tag);
        kind = K_MISS;
        line = ent_line;
        st   = ent_st;
        if (hit) begin
            if (is_store) begin
                kind = K_ST_HIT;
                line = put_word(ent_line, req_off, req_data);
                st   = ST_DIRTY;
            end else begin
                kind = K_LD_HIT;
            end
        end
        word = get_word(line, req_off);
    end

endmodule

// File: rtl/cau_array_unit.sv
module cau_array_unit
    import cau_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = ADDR_W - LINE_OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [1:0]        resp_kind,
    output logic [WORD_W-1:0] resp_word,
    output logic [LINE_W-1:0] resp_line,
    output logic [TAG_W-1:0]  resp_tag,
    output logic [1:0]        resp_status,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_index,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [1:0]        upd_status
);
    typedef struct packed {
        logic              store;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WOFF_W-1:0] off;
        logic [WORD_W-1:0] data;
    } shadow_t;

    shadow_t      sh;
    logic         pending;
    logic         req_fire, resp_fire, st_fire;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] ent_tag;
    line_state_e  ent_st, out_st;
    line_t        ent_line, out_line;
    lookup_kind_e kind;
    logic         unused_boff;

    assign unused_boff = ^req_addr[BOFF_W-1:0];
    assign req_idx     = req_addr[LINE_OFF_W +: IDX_W];
    assign req_ready   = !pending;
    assign resp_valid  = pending;
    assign req_fire    = req_valid && req_ready;
    assign resp_fire   = resp_valid && resp_ready;
    assign st_fire     = resp_fire && (kind == K_ST_HIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            sh      <= '0;
        end else if (req_fire) begin
            pending <= 1'b1;
            sh      <= '{store: req_store,
                         tag:   req_addr[ADDR_W-1 -: TAG_W],
                         idx:   req_idx,
                         off:   word_sel(req_addr),
                         data:  req_wdata};
        end else if (resp_fire) begin
            pending <= 1'b0;
        end
    end

    cau_meta_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_meta (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (req_fire),
        .rd_idx    (req_idx),
        .wr_en     (upd_valid),
        .wr_idx    (upd_index),
        .wr_tag    (upd_tag),
        .wr_st     (line_state_e'(upd_status)),
        .dirty_en  (st_fire),
        .dirty_idx (sh.idx),
        .q_tag     (ent_tag),
        .q_st      (ent_st)
    );

    cau_line_store #(.IDX_W(IDX_W)) u_lines (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (req_fire),
        .rd_idx  (req_idx),
        .wr_en   (upd_valid),
        .wr_idx  (upd_index),
        .wr_line (line_t'(upd_line)),
        .ww_en   (st_fire),
        .ww_idx  (sh.idx),
        .ww_off  (sh.off),
        .ww_data (sh.data),
        .q       (ent_line)
    );

    cau_lookup #(.TAG_W(TAG_W)) u_cmp (
        .is_store (sh.store),
        .req_tag  (sh.tag),
        .req_off  (sh.off),
        .req_data (sh.data),
        .ent_tag  (ent_tag),
        .ent_st   (ent_st),
        .ent_line (ent_line),
        .kind     (kind),
        .word     (resp_word),
        .line     (out_line),
        .st       (out_st)
    );

    assign resp_kind   = kind;
    assign resp_line   = out_line;
    assign resp_tag    = ent_tag;
    assign resp_status = out_st;

    AST_HIT_TAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind != K_MISS) |-> (resp_tag == sh.tag)); // R3
    AST_INVALID_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && ent_st == ST_INVALID) |-> (resp_kind == K_MISS && resp_status == ST_INVALID)); // R7
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid); // R9
    AST_RESP_HELD: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && !req_ready)); // R9
    AST_STORE_HIT_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == K_ST_HIT) |-> (resp_status == ST_DIRTY && resp_word == sh.data)); // R5

endmodule

// File: tb/cau_array_unit_tb.sv
module cau_array_unit_tb;
    import cau_pkg::*;

    localparam int IDX_W = 4;
    localparam int TAG_W = ADDR_W - LINE_OFF_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_store = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic              resp_valid;
    logic              resp_ready = 1'b0;
    logic [1:0]        resp_kind, resp_status;
    logic [WORD_W-1:0] resp_word;
    logic [LINE_W-1:0] resp_line;
    logic [TAG_W-1:0]  resp_tag;
    logic              upd_valid = 1'b0;
    logic [IDX_W-1:0]  upd_index = '0;
    logic [LINE_W-1:0] upd_line = '0;
    logic [TAG_W-1:0]  upd_tag = '0;
    logic [1:0]        upd_status = '0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0]        c_kind, c_st;
    logic [WORD_W-1:0] c_word;
    logic [LINE_W-1:0] c_line;
    logic [TAG_W-1:0]  c_tag;

    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic [1:0]        r_st;
    logic [7:0]        r_seed;

    always #10 clk = ~clk;

    cau_array_unit #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_kind(resp_kind),
        .resp_word(resp_word), .resp_line(resp_line), .resp_tag(resp_tag),
        .resp_status(resp_status),
        .upd_valid(upd_valid), .upd_index(upd_index), .upd_line(upd_line),
        .upd_tag(upd_tag), .upd_status(upd_status)
    );

    function automatic logic [WORD_W-1:0] lw(input logic [7:0] s, input int w);
        return 32'hC0DE_0000 | (32'(s) << 8) | 32'(w);
    endfunction

    function automatic logic [LINE_W-1:0] mk_line(input logic [7:0] s);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < LINE_WORDS; w++) l[w*WORD_W +: WORD_W] = lw(s, w);
        return l;
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [TAG_W-1:0] t, input int idx,
                                                  input int w, input int b);
        return {t, IDX_W'(idx), WOFF_W'(w), BOFF_W'(b)};
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic drive_upd(input bit on);
        upd_valid  = on;
        upd_index  = r_idx;
        upd_tag    = r_tag;
        upd_status = r_st;
        upd_line   = mk_line(r_seed);
    endtask

    task automatic refill(input int idx, input logic [TAG_W-1:0] t, input logic [1:0] st,
                          input logic [7:0] s);
        r_idx = IDX_W'(idx); r_tag = t; r_st = st; r_seed = s;
        @(negedge clk);
        drive_upd(1'b1);
        @(negedge clk);
        drive_upd(1'b0);
    endtask

    // race: 0 none, 1 refill during the stall, 2 refill with the request
    task automatic lookup(input bit st, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                          input int hold, input int race, input bit intrude,
                          input logic [ADDR_W-1:0] ia);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d;
        if (race == 2) drive_upd(1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (race == 2) drive_upd(1'b0);
        chk("R9 resp_valid after accept", 64'(resp_valid), 64'd1);
        for (int i = 0; i < hold; i++) begin
            if (race == 1 && i == 0) drive_upd(1'b1);
            if (intrude && i == 0) begin
                req_valid = 1'b1; req_store = 1'b1; req_addr = ia; req_wdata = 32'h0;
            end
            @(posedge clk);
            @(negedge clk);
            if (race == 1 && i == 0) drive_upd(1'b0);
            chk("R9 resp held", 64'(resp_valid), 64'd1);
            chk("R9 req_ready low", 64'(req_ready), 64'd0);
        end
        req_valid = 1'b0;
        c_kind = resp_kind; c_word = resp_word; c_line = resp_line;
        c_tag = resp_tag; c_st = resp_status;
        resp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resp_ready = 1'b0;
        chk("R9 resp drops after take", 64'(resp_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 resp_valid", 64'(resp_valid), 64'd0);
        lookup(1'b0, mk_addr(22'h5, 2, 0, 0), 0, 0, 0, 0, 0);
        chk("R1 kind after reset", 64'(c_kind), 64'd0);
        chk("R7 state after reset", 64'(c_st), 64'd0);
    endtask

    task automatic t_load_hit;
        refill(3, 22'h1ABCD, 2'd1, 8'h11);
        lookup(1'b0, mk_addr(22'h1ABCD, 3, 5, 0), 0, 0, 0, 0, 0);
        chk("R3 load hit kind", 64'(c_kind), 64'd1);
        chk("R4 load word", 64'(c_word), 64'(lw(8'h11, 5)));
        chk("R3 hit tag", 64'(c_tag), 64'h1ABCD);
        chk("R8 refill state", 64'(c_st), 64'd1);
        lookup(1'b0, mk_addr(22'h1ABCD, 3, 5, 3), 0, 0, 0, 0, 0);
        chk("R2 byte offset ignored", 64'(c_word), 64'(lw(8'h11, 5)));
        lookup(1'b0, mk_addr(22'h1ABCD, 3, 15, 0), 0, 0, 0, 0, 0);
        chk("R2 last word", 64'(c_word), 64'(lw(8'h11, 15)));
        chk("R4 entry unchanged", 64'(c_st), 64'd1);
    endtask

    task automatic t_store_hit;
        lookup(1'b1, mk_addr(22'h1ABCD, 3, 7, 0), 32'hDEAD_BEEF, 0, 0, 0, 0);
        chk("R5 store hit kind", 64'(c_kind), 64'd2);
        chk("R5 merged word", 64'(c_word), 64'hDEAD_BEEF);
        chk("R5 line word 7", 64'(c_line[7*WORD_W +: WORD_W]), 64'hDEAD_BEEF);
        chk("R5 neighbour word", 64'(c_line[6*WORD_W +: WORD_W]), 64'(lw(8'h11, 6)));
        chk("R5 state dirty", 64'(c_st), 64'd2);
        lookup(1'b0, mk_addr(22'h1ABCD, 3, 7, 0), 0, 0, 0, 0, 0);
        chk("R5 stored word persists", 64'(c_word), 64'hDEAD_BEEF);
        chk("R5 entry dirty", 64'(c_st), 64'd2);
    endtask

    task automatic t_miss_victim;
        lookup(1'b1, mk_addr(22'h00042, 3, 1, 0), 32'h1234_5678, 0, 0, 0, 0);
        chk("R6 miss kind", 64'(c_kind), 64'd0);
        chk("R6 victim tag", 64'(c_tag), 64'h1ABCD);
        chk("R6 victim state", 64'(c_st), 64'd2);
        chk("R6 victim word 7", 64'(c_line[7*WORD_W +: WORD_W]), 64'hDEAD_BEEF);
        chk("R6 victim word 1", 64'(c_line[1*WORD_W +: WORD_W]), 64'(lw(8'h11, 1)));
        lookup(1'b0, mk_addr(22'h1ABCD, 3, 1, 0), 0, 0, 0, 0, 0);
        chk("R6 entry kept after miss", 64'(c_kind), 64'd1);
        chk("R6 word kept after miss", 64'(c_word), 64'(lw(8'h11, 1)));
    endtask

    task automatic t_index_edges;
        refill(0, 22'h3FFFFF, 2'd1, 8'h20);
        refill(15, 22'h000001, 2'd2, 8'h2F);
        lookup(1'b0, mk_addr(22'h3FFFFF, 0, 15, 0), 0, 0, 0, 0, 0);
        chk("R3 index 0 hit", 64'(c_kind), 64'd1);
        chk("R2 index 0 word", 64'(c_word), 64'(lw(8'h20, 15)));
        lookup(1'b0, mk_addr(22'h000001, 15, 0, 0), 0, 0, 0, 0, 0);
        chk("R3 index 15 hit", 64'(c_kind), 64'd1);
        chk("R8 index 15 state", 64'(c_st), 64'd2);
        lookup(1'b0, mk_addr(22'h000001, 0, 0, 0), 0, 0, 0, 0, 0);
        chk("R3 tag mismatch miss", 64'(c_kind), 64'd0);
        chk("R6 resident tag", 64'(c_tag), 64'h3FFFFF);
    endtask

    task automatic t_invalid;
        refill(15, 22'h000001, 2'd0, 8'h30);
        lookup(1'b0, mk_addr(22'h000001, 15, 0, 0), 0, 0, 0, 0, 0);
        chk("R7 invalid never hits", 64'(c_kind), 64'd0);
        chk("R7 invalid state reported", 64'(c_st), 64'd0);
    endtask

    task automatic t_backpressure;
        lookup(1'b0, mk_addr(22'h3FFFFF, 0, 2, 0), 0, 3, 0, 1'b1, mk_addr(22'h3FFFFF, 0, 4, 0));
        chk("R9 stalled load kind", 64'(c_kind), 64'd1);
        chk("R9 stalled load word", 64'(c_word), 64'(lw(8'h20, 2)));
        lookup(1'b0, mk_addr(22'h3FFFFF, 0, 4, 0), 0, 0, 0, 0, 0);
        chk("R9 ignored store word", 64'(c_word), 64'(lw(8'h20, 4)));
        chk("R9 ignored store state", 64'(c_st), 64'd1);
    endtask

    task automatic t_refill_race;
        refill(9, 22'h00AAA, 2'd1, 8'h40);
        r_idx = 4'd9; r_tag = 22'h00BBB; r_st = 2'd1; r_seed = 8'h41;
        lookup(1'b0, mk_addr(22'h00BBB, 9, 3, 0), 0, 2, 1, 0, 0);
        chk("R10 refill while pending kind", 64'(c_kind), 64'd1);
        chk("R10 refill while pending word", 64'(c_word), 64'(lw(8'h41, 3)));
        r_idx = 4'd9; r_tag = 22'h00CCC; r_st = 2'd2; r_seed = 8'h42;
        lookup(1'b0, mk_addr(22'h00CCC, 9, 6, 0), 0, 0, 2, 0, 0);
        chk("R10 refill with request kind", 64'(c_kind), 64'd1);
        chk("R10 refill with request word", 64'(c_word), 64'(lw(8'h42, 6)));
        chk("R10 refill with request state", 64'(c_st), 64'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_hit();
        t_store_hit();
        t_miss_victim();
        t_index_edges();
        t_invalid();
        t_backpressure();
        t_refill_race();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule